// File: doc/BRIEF.md
# Address Generation Register File

This block produces memory addresses for a signal-processing datapath. It holds eight address pointers. Each pointer is tied for good to its own offset register and its own modifier register. In each cycle a caller may present one access. The access names a pointer index and one of eight addressing modes. One clock edge later the block returns a 16-bit effective address, together with the 2-bit memory-space tag that came with the request. When the mode calls for it, the pointer is rewritten in the same edge.

The modifier register paired with a pointer selects how that pointer's arithmetic works:

- **Linear:** plain wrap-around at 16 bits.
- **Circular:** the pointer stays inside a buffer whose size is the modifier plus one. The buffer starts on a boundary that has the next power of two at or above that size.
- **Reverse-carry:** the pointer is bit-reversed, the step is added, and the result is reversed back.

A separate load port writes any pointer, offset or modifier register. A freshly loaded register is not meant to be used by the very next access. The block still performs that access with the new value, and it raises a hazard flag next to the address so the sequencer can see the violation.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer and every offset register holds 0, and every modifier holds 16'hFFFF, so all arithmetic starts out linear.
- R2: An access on index i reads pointer i, offset i and modifier i only; registers of other indices have no effect on it.
- R3: Mode 2 (post-increment) and mode 3 (post-decrement) return the current pointer and then step it by +1 or -1.
- R4: Mode 4 (pre-decrement) steps the pointer by -1, returns the stepped value and stores it.
- R5: Mode 5 (post-add offset) and mode 6 (post-subtract offset) return the current pointer and then step it by plus or minus the signed 16-bit offset.
- R6: Mode 7 (indexed) returns pointer plus offset, with the paired modifier's arithmetic applied, and leaves the pointer unchanged; mode 1 (indirect) returns the pointer unchanged.
- R7: With modifier 16'hFFFF, stepping wraps modulo 2^16 (for example 16'hFFFF + 1 gives 16'h0000).
- R8: With modifier m in 1..32767, a step that leaves the buffer [base, base+m] wraps by m+1 in either direction. The base is the pointer with its k low bits cleared, where 2^k is the smallest power of two above m.
- R9: In circular arithmetic, a step whose magnitude equals exactly 2^k is applied linearly, which moves the pointer to the neighbouring buffer.
- R10: With modifier 0, a step is computed as bitreverse(bitreverse(pointer) + step).
- R11: Mode 0 (absolute) returns the supplied absolute address and changes no register.
- R12: The hazard output is high exactly when the returned access read a register (pointer for modes 1-7; offset for modes 5-7; modifier for modes 2-7) that the load port wrote in the previous cycle. The access still uses the loaded value. Load kind codes are 0 pointer, 1 offset, 2 modifier.
- R13: When a load to pointer i and a pointer update on index i happen in the same cycle, the loaded value is kept.
- R14: The valid flag, address, space tag and hazard are registered and appear one cycle after the access; the valid flag is low after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_mode | input | 3 | Addressing mode code (0..7) |
| acc_idx | input | 3 | Pointer index |
| acc_space | input | 2 | Memory-space tag passed through |
| abs_addr | input | 16 | Address used by absolute mode |
| ld_en | input | 1 | Load port write enable |
| ld_kind | input | 2 | 0 pointer, 1 offset, 2 modifier |
| ld_idx | input | 3 | Index of the register to load |
| ld_data | input | 16 | Value to load |
| ea_valid | output | 1 | Registered: an address is present |
| ea | output | 16 | Registered effective address |
| ea_space | output | 2 | Registered space tag |
| hazard | output | 1 | Registered load-use violation flag |

## Verification
The hardest cases to reach combine several conditions in a single cycle:

- A load and an auto-update that strike the same pointer together.
- A modifier load that is immediately followed by a step, so the wrap comes from a value loaded one cycle earlier.
- A circular pointer that sits on the last word of its buffer when it is stepped.

The stimulus first places each pointer at a buffer edge with loads and idle cycles. It then issues the colliding or back-to-back access directly. Every result is compared against hand-derived addresses, and each update is read back with an indirect access.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AW = 16;

    typedef enum logic [2:0] {
        MD_ABS     = 3'd0,
        MD_IND     = 3'd1,
        MD_POSTINC = 3'd2,
        MD_POSTDEC = 3'd3,
        MD_PREDEC  = 3'd4,
        MD_POSTADD = 3'd5,
        MD_POSTSUB = 3'd6,
        MD_INDEXED = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        LK_PTR = 2'd0,
        LK_OFS = 2'd1,
        LK_MOD = 2'd2,
        LK_NONE = 2'd3
    } ld_kind_e;

    typedef enum logic [1:0] {
        AR_LINEAR,
        AR_CIRCULAR,
        AR_REVERSE
    } arith_e;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] ofs;
        logic [AW-1:0] modv;
    } triple_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [1:0]    space;
        logic          hazard;
    } result_t;

    function automatic arith_e classify(input logic [AW-1:0] m);
        if (m == '1)          return AR_LINEAR;
        else if (m == '0)     return AR_REVERSE;
        else if (!m[AW-1])    return AR_CIRCULAR;
        else                  return AR_LINEAR;
    endfunction

    function automatic logic [AW-1:0] bit_flip(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
        return o;
    endfunction

    function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        o = v;
        for (int s = 1; s < AW; s = s * 2) o = o | (o >> s);
        return o;
    endfunction

    function automatic logic uses_ptr(input agu_mode_e md);
        return md != MD_ABS;
    endfunction

    function automatic logic uses_ofs(input agu_mode_e md);
        return md == MD_POSTADD || md == MD_POSTSUB || md == MD_INDEXED;
    endfunction

    function automatic logic uses_mod(input agu_mode_e md);
        return md != MD_ABS && md != MD_IND;
    endfunction

    function automatic logic writes_ptr(input agu_mode_e md);
        return md == MD_POSTINC || md == MD_POSTDEC || md == MD_PREDEC ||
               md == MD_POSTADD || md == MD_POSTSUB;
    endfunction

    function automatic logic emits_step(input agu_mode_e md);
        return md == MD_PREDEC || md == MD_INDEXED;
    endfunction

endpackage

// File: rtl/agu_step.sv
module agu_step
    import agu_pkg::*;
(
    input  logic [AW-1:0] base,
    input  logic [AW:0]   delta,
    input  logic [AW-1:0] modv,
    output logic [AW-1:0] next
);
    localparam int SW = AW + 2;

    arith_e              kind;
    logic [AW-1:0]       mask;
    logic [AW:0]         span;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] d_s;
    logic signed [SW-1:0] size_s;
    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] fix_s;
    logic                jump;
    logic [AW-1:0]       lin_res;
    logic [AW-1:0]       circ_res;
    logic [AW-1:0]       rev_res;

    always_comb begin
        kind    = classify(modv);
        mask    = smear(modv);
        span    = {1'b0, mask} + {{AW{1'b0}}, 1'b1};
        lin_res = base + delta[AW-1:0];
        rev_res = bit_flip(bit_flip(base) + delta[AW-1:0]);
        off_s   = SW'({2'b00, base & mask});
        d_s     = {delta[AW], delta};
        size_s  = SW'({2'b00, modv}) + SW'(1);
        sum_s   = off_s + d_s;
        if (sum_s >= size_s)      fix_s = sum_s - size_s;
        else if (sum_s < 0)       fix_s = sum_s + size_s;
        else                      fix_s = sum_s;
        jump    = (delta == span) || (delta == ((~span) + 1'b1));
        circ_res = (base & ~mask) | (fix_s[AW-1:0] & mask);
        unique case (kind)
            AR_CIRCULAR: next = jump ? lin_res : circ_res;
            AR_REVERSE:  next = rev_res;
            default:     next = lin_res;
        endcase
    end

endmodule

// File: rtl/agu_bank.sv
module agu_bank
    import agu_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  ld_kind_e      ld_kind,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [AW-1:0] wb_data,
    input  logic [IW-1:0] rd_idx,
    output triple_t       rd
);
    triple_t regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic hit_ld;
        assign hit_ld = ld_en && (ld_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i].ptr  <= '0;
                regs[i].ofs  <= '0;
                regs[i].modv <= '1;
            end else begin
                if (hit_ld && ld_kind == LK_PTR)
                    regs[i].ptr <= ld_data;
                else if (wb_en && wb_idx == IW'(i))
                    regs[i].ptr <= wb_data;
                if (hit_ld && ld_kind == LK_OFS)
                    regs[i].ofs <= ld_data;
                if (hit_ld && ld_kind == LK_MOD)
                    regs[i].modv <= ld_data;
            end
        end

        // R1
        mod_reset_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (regs[i].modv == '1 && regs[i].ptr == '0 && regs[i].ofs == '0));
    end

    assign rd = regs[rd_idx];

    // R13
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_kind == LK_PTR) |=> regs[$past(ld_idx)].ptr == $past(ld_data));

endmodule

// File: rtl/agu_hazard.sv
module agu_hazard
    import agu_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  ld_kind_e      ld_kind,
    input  logic [IW-1:0] ld_idx,
    input  logic          acc_valid,
    input  agu_mode_e     acc_mode,
    input  logic [IW-1:0] acc_idx,
    output logic          hit
);
    logic [NREG-1:0] fresh_ptr;
    logic [NREG-1:0] fresh_ofs;
    logic [NREG-1:0] fresh_mod;

    for (genvar i = 0; i < NREG; i++) begin : g_flag
        logic sel;
        assign sel = ld_en && (ld_idx == IW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                fresh_ptr[i] <= 1'b0;
                fresh_ofs[i] <= 1'b0;
                fresh_mod[i] <= 1'b0;
            end else begin
                fresh_ptr[i] <= sel && ld_kind == LK_PTR;
                fresh_ofs[i] <= sel && ld_kind == LK_OFS;
                fresh_mod[i] <= sel && ld_kind == LK_MOD;
            end
        end
    end

    always_comb begin
        hit = acc_valid && (
              (uses_ptr(acc_mode) && fresh_ptr[acc_idx]) ||
              (uses_ofs(acc_mode) && fresh_ofs[acc_idx]) ||
              (uses_mod(acc_mode) && fresh_mod[acc_idx]));
    end

    // R12
    single_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({fresh_ptr, fresh_ofs, fresh_mod}) <= 1);

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [2:0]    acc_mode,
    input  logic [IW-1:0] acc_idx,
    input  logic [1:0]    acc_space,
    input  logic [AW-1:0] abs_addr,
    input  logic          ld_en,
    input  logic [1:0]    ld_kind,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_data,
    output logic          ea_valid,
    output logic [AW-1:0] ea,
    output logic [1:0]    ea_space,
    output logic          hazard
);
    agu_mode_e     mode;
    ld_kind_e      lk;
    triple_t       cur;
    logic [AW:0]   delta;
    logic [AW-1:0] stepped;
    logic          wb_en;
    logic          hz;
    result_t       res_d;
    result_t       res_q;

    assign mode = agu_mode_e'(acc_mode);
    assign lk   = ld_kind_e'(ld_kind);

    agu_bank #(.NREG(NREG)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_kind (lk),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wb_en   (wb_en),
        .wb_idx  (acc_idx),
        .wb_data (stepped),
        .rd_idx  (acc_idx),
        .rd      (cur)
    );

    agu_step i_step (
        .base  (cur.ptr),
        .delta (delta),
        .modv  (cur.modv),
        .next  (stepped)
    );

    agu_hazard #(.NREG(NREG)) i_hazard (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_kind   (lk),
        .ld_idx    (ld_idx),
        .acc_valid (acc_valid),
        .acc_mode  (mode),
        .acc_idx   (acc_idx),
        .hit       (hz)
    );

    always_comb begin
        unique case (mode)
            MD_POSTINC:             delta = (AW+1)'(1);
            MD_POSTDEC, MD_PREDEC:  delta = '1;
            MD_POSTADD, MD_INDEXED: delta = {cur.ofs[AW-1], cur.ofs};
            MD_POSTSUB:             delta = ~{cur.ofs[AW-1], cur.ofs} + 1'b1;
            default:                delta = '0;
        endcase
        wb_en = acc_valid && writes_ptr(mode);
        res_d.valid  = acc_valid;
        res_d.space  = acc_space;
        res_d.hazard = hz;
        if (mode == MD_ABS)        res_d.addr = abs_addr;
        else if (emits_step(mode)) res_d.addr = stepped;
        else                       res_d.addr = cur.ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign ea_valid = res_q.valid;
    assign ea       = res_q.addr;
    assign ea_space = res_q.space;
    assign hazard   = res_q.hazard;

    // R3
    post_ea_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (mode == MD_POSTINC || mode == MD_POSTDEC ||
                       mode == MD_POSTADD || mode == MD_POSTSUB))
        |=> ea == $past(cur.ptr));

    // R11
    abs_ea_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && mode == MD_ABS) |=> (ea_valid && ea == $past(abs_addr) && !hazard));

    // R12
    hazard_src_chk: assert property (@(posedge clk) disable iff (rst)
        hazard |-> ($past(ld_en, 2) && ea_valid));

    // R14
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !ea_valid);

endmodule

// File: tb/test_agu_top.sv
`timescale 1ns/100ps
module test_agu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [2:0]  acc_mode;
    logic [2:0]  acc_idx;
    logic [1:0]  acc_space;
    logic [15:0] abs_addr;
    logic        ld_en;
    logic [1:0]  ld_kind;
    logic [2:0]  ld_idx;
    logic [15:0] ld_data;
    logic        ea_valid;
    logic [15:0] ea;
    logic [1:0]  ea_space;
    logic        hazard;

    typedef struct {
        logic        v;
        logic [15:0] a;
        logic [1:0]  s;
        logic        h;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    agu_top i_agu_top (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .acc_idx(acc_idx), .acc_space(acc_space), .abs_addr(abs_addr),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
        .ea_valid(ea_valid), .ea(ea), .ea_space(ea_space), .hazard(hazard)
    );

    task automatic drive(input logic v, input logic [2:0] md, input logic [2:0] ix,
                         input logic [1:0] sp, input logic [15:0] ab,
                         input logic le, input logic [1:0] lk, input logic [2:0] li,
                         input logic [15:0] ldv, input logic [15:0] ea_e,
                         input logic hz_e, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = v; acc_mode = md; acc_idx = ix; acc_space = sp; abs_addr = ab;
        ld_en = le; ld_kind = lk; ld_idx = li; ld_data = ldv;
        e.v = v; e.a = ea_e; e.s = sp; e.h = hz_e; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic acc(input logic [2:0] md, input logic [2:0] ix,
                       input logic [15:0] ea_e, input logic hz_e, input string tag);
        drive(1'b1, md, ix, 2'd1, 16'h0, 1'b0, 2'd0, 3'd0, 16'h0, ea_e, hz_e, tag);
    endtask

    task automatic load(input logic [1:0] lk, input logic [2:0] li, input logic [15:0] d);
        drive(1'b0, 3'd0, 3'd0, 2'd0, 16'h0, 1'b1, lk, li, d, 16'h0, 1'b0, "R14 idle");
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 3'd0, 2'd0, 16'h0, 1'b0, 2'd0, 3'd0, 16'h0, 16'h0, 1'b0, "R14 idle");
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (ea_valid !== e.v) begin
                bad++;
                $display("FAIL %s valid act=%b exp=%b", e.tag, ea_valid, e.v);
            end else if (e.v && (ea !== e.a || ea_space !== e.s || hazard !== e.h)) begin
                bad++;
                $display("FAIL %s act ea=%h sp=%0d hz=%b exp ea=%h sp=%0d hz=%b",
                         e.tag, ea, ea_space, hazard, e.a, e.s, e.h);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        acc_valid = 0; acc_mode = 0; acc_idx = 0; acc_space = 0; abs_addr = 0;
        ld_en = 0; ld_kind = 0; ld_idx = 0; ld_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset pointer value; R7 linear arithmetic after reset
        acc(3'd1, 3'd0, 16'h0000, 1'b0, "R1 reset ptr");
        acc(3'd2, 3'd5, 16'h0000, 1'b0, "R1 postinc reset");
        acc(3'd1, 3'd5, 16'h0001, 1'b0, "R1 linear step");
        // R3 R4 R12
        load(2'd0, 3'd1, 16'h1000);
        acc(3'd1, 3'd1, 16'h1000, 1'b1, "R12 ptr hazard");
        acc(3'd2, 3'd1, 16'h1000, 1'b0, "R3 postinc");
        acc(3'd2, 3'd1, 16'h1001, 1'b0, "R3 postinc 2");
        acc(3'd3, 3'd1, 16'h1002, 1'b0, "R3 postdec");
        acc(3'd4, 3'd1, 16'h1000, 1'b0, "R4 predec");
        acc(3'd1, 3'd1, 16'h1000, 1'b0, "R4 stored");
        // R5 R6
        load(2'd1, 3'd1, 16'h0010);
        idle();
        acc(3'd5, 3'd1, 16'h1000, 1'b0, "R5 postadd");
        acc(3'd6, 3'd1, 16'h1010, 1'b0, "R5 postsub");
        acc(3'd7, 3'd1, 16'h1010, 1'b0, "R6 indexed");
        acc(3'd1, 3'd1, 16'h1000, 1'b0, "R6 unchanged");
        // R12 offset hazard, new value used
        load(2'd1, 3'd1, 16'h0003);
        acc(3'd5, 3'd1, 16'h1000, 1'b1, "R12 ofs hazard");
        acc(3'd1, 3'd1, 16'h1003, 1'b0, "R12 loaded ofs used");
        // R8 circular buffer size 0x548 at 0x800; modifier hazard
        load(2'd0, 3'd3, 16'h0D47);
        load(2'd2, 3'd3, 16'h0547);
        acc(3'd2, 3'd3, 16'h0D47, 1'b1, "R12 mod hazard");
        acc(3'd1, 3'd3, 16'h0800, 1'b0, "R8 wrap up");
        acc(3'd3, 3'd3, 16'h0800, 1'b0, "R8 postdec edge");
        acc(3'd1, 3'd3, 16'h0D47, 1'b0, "R8 wrap down");
        load(2'd0, 3'd3, 16'h0800);
        idle();
        acc(3'd4, 3'd3, 16'h0D47, 1'b0, "R8 predec wrap");
        // R2 pairing: index 3 offset independent of index 1
        load(2'd1, 3'd3, 16'h0005);
        load(2'd0, 3'd3, 16'h0D46);
        idle();
        acc(3'd5, 3'd3, 16'h0D46, 1'b0, "R2 postadd own ofs");
        acc(3'd1, 3'd3, 16'h0803, 1'b0, "R8 ofs wrap up");
        acc(3'd6, 3'd3, 16'h0803, 1'b0, "R8 postsub");
        acc(3'd1, 3'd3, 16'h0D46, 1'b0, "R8 ofs wrap down");
        acc(3'd7, 3'd3, 16'h0803, 1'b0, "R6 indexed circular");
        acc(3'd1, 3'd3, 16'h0D46, 1'b0, "R6 circular unchanged");
        // R9 jump to next buffer
        load(2'd1, 3'd3, 16'h0800);
        load(2'd0, 3'd3, 16'h0800);
        idle();
        acc(3'd5, 3'd3, 16'h0800, 1'b0, "R9 jump");
        acc(3'd1, 3'd3, 16'h1000, 1'b0, "R9 next buffer");
        // R10 reverse carry
        load(2'd2, 3'd4, 16'h0000);
        idle();
        acc(3'd2, 3'd4, 16'h0000, 1'b0, "R10 postinc");
        acc(3'd2, 3'd4, 16'h8000, 1'b0, "R10 postinc 2");
        acc(3'd3, 3'd4, 16'h4000, 1'b0, "R10 postdec");
        load(2'd1, 3'd4, 16'h0002);
        idle();
        acc(3'd7, 3'd4, 16'hC000, 1'b0, "R10 indexed");
        // R13 load wins over update
        load(2'd0, 3'd2, 16'h0100);
        idle();
        drive(1'b1, 3'd2, 3'd2, 2'd3, 16'h0, 1'b1, 2'd0, 3'd2, 16'h0200,
              16'h0100, 1'b0, "R13 collide");
        acc(3'd1, 3'd2, 16'h0200, 1'b1, "R13 load kept");
        // R11 absolute
        load(2'd0, 3'd0, 16'h0055);
        drive(1'b1, 3'd0, 3'd0, 2'd2, 16'hBEEF, 1'b0, 2'd0, 3'd0, 16'h0,
              16'hBEEF, 1'b0, "R11 absolute");
        acc(3'd1, 3'd0, 16'h0055, 1'b0, "R11 no change");
        // R7 linear wrap at top
        load(2'd0, 3'd0, 16'hFFFF);
        idle();
        acc(3'd2, 3'd0, 16'hFFFF, 1'b0, "R7 wrap");
        acc(3'd1, 3'd0, 16'h0000, 1'b0, "R7 wrapped");
        idle();
        idle();
        wait (q.size() == 0);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule